// File: doc/BRIEF.md
# Lightweight Interrupt Entry and Inter-Core Trap Routing

This block sits beside one core of a multi-core processor and performs the hardware part of taking an interrupt or trap. On entry it copies the program counter and a few status flags into dedicated shadow registers and exchanges the active stack pointer with the alternate (handler) stack pointer. It also forms the handler address by wiring the cause code into the low bits of an aligned vector-base register, so no adder is needed. Nothing is pushed to memory. A return request swaps the stack pointers back and unmasks the core.

A software trap value carries a target core field. If the field is zero or names this core, the trap is taken locally. Otherwise the trap leaves the block as an inter-processor interrupt request to the named core. External hardware interrupts are accepted only on one home core. Incoming inter-processor interrupts that arrive while the core is masked are held in a one-deep pending latch and taken after the return.

Top module: `irq_entry_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters a known state: unmasked, no pending IPI, all pulses low, vector base zero, active stack pointer `SP_RST`, alternate stack pointer `ALT_RST`.
- R2: On an accepted event, one cycle later `entry_valid` pulses for one cycle, `in_handler` is high, `saved_pc` holds the `pc_in` of the accepting cycle and `saved_status` holds its `status_in`.
- R3: `handler_pc` equals the vector base with bits [9:2] replaced by the 8-bit cause and bits [1:0] zero. A base write keeps only `wr_data[31:10]`; the base in effect before the write is used in the write cycle.
- R4: Entry exchanges `sp_active` and `sp_alt`; the return exchanges them back.
- R5: `ret_req` while `in_handler` is high clears `in_handler` and pulses `ret_valid` one cycle later. `ret_req` while unmasked changes nothing.
- R6: When several events are allowed in the same cycle, a local trap wins over an external interrupt, and an external interrupt wins over an IPI.
- R7: In `trap_val`, bits [15:12] are the target core and bits [7:0] are the cause. A target of 0 or one equal to `core_id` makes the trap local.
- R8: A non-local trap raises `ipi_out_valid` for one cycle, one cycle later, with `ipi_out_target` and `ipi_out_cause` taken from the trap value. This happens whether or not the core is masked, and the trap has no local effect.
- R9: `ext_irq` is honoured only when `core_id` equals `HOME_CORE`. On any other core it has no effect.
- R10: While `in_handler` is high, local traps are dropped and `ext_irq` is not taken. A level `ext_irq` still asserted after the return is taken then.
- R11: An IPI that is not taken in its arrival cycle is latched, and `ipi_pending` is set one cycle later. A latched IPI is taken after the return, ranked as an IPI. Further IPIs that arrive while one is latched are dropped.
- R12: `sp_wr` and `alt_wr` load `wr_data` into the active and alternate stack pointer. In a cycle that enters or returns, these writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_id | input | ID_W | Identity of this core |
| pc_in | input | AW | Current program counter |
| status_in | input | ST_W | Status flags to preserve |
| base_wr | input | 1 | Load vector base from `wr_data` |
| sp_wr | input | 1 | Load active stack pointer from `wr_data` |
| alt_wr | input | 1 | Load alternate stack pointer from `wr_data` |
| wr_data | input | AW | Write data for base and stack pointers |
| trap_req | input | 1 | Software trap request |
| trap_val | input | TRAP_W | Trap value: target core and cause |
| ext_irq | input | 1 | Level external interrupt |
| ext_cause | input | 8 | Cause for the external interrupt |
| ipi_in_valid | input | 1 | Incoming inter-processor interrupt |
| ipi_in_cause | input | 8 | Cause of the incoming IPI |
| ret_req | input | 1 | Return from handler |
| entry_valid | output | 1 | One-cycle pulse: entry performed |
| entry_cause | output | 8 | Cause of the last entry |
| handler_pc | output | AW | Handler address of the last entry |
| saved_pc | output | AW | Shadow copy of the interrupted PC |
| saved_status | output | ST_W | Shadow copy of the interrupted status |
| in_handler | output | 1 | Core is in a handler; further events masked |
| sp_active | output | AW | Active stack pointer |
| sp_alt | output | AW | Alternate stack pointer |
| ret_valid | output | 1 | One-cycle pulse: return performed |
| ipi_pending | output | 1 | An IPI is latched awaiting service |
| ipi_out_valid | output | 1 | One-cycle forwarded trap to another core |
| ipi_out_target | output | ID_W | Target core of the forwarded trap |
| ipi_out_cause | output | 8 | Cause of the forwarded trap |

## Verification
Two pairs of functions can fall in the same cycle. One pair is a return and an incoming IPI or a still-asserted external line: the event must wait one cycle after the return and then be taken, not lost. The other pair is a remote trap forwarded in the same cycle that a local event is accepted or a stack-pointer write is dropped. Both pairs are set up on purpose in the directed part. A long randomized run then makes them happen often. A behavioural reference model judges every output on every clock, and the run also checks the cause, vector and stack pointers that are expected at each coincidence.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CAUSE_W  = 8;
  localparam int SLOT_LSB = 2;
  localparam int VEC_LSB  = CAUSE_W + SLOT_LSB;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_TRAP = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_IPI  = 2'd3
  } src_e;
endpackage

// File: rtl/irq_trap_route.sv
module irq_trap_route
  import irq_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int TRAP_W = 16
) (
  input  logic [TRAP_W-1:0]  trap_val,
  input  logic [ID_W-1:0]    core_id,
  output logic [ID_W-1:0]    tgt,
  output logic [CAUSE_W-1:0] cause,
  output logic               local_hit
);
  assign tgt = trap_val[TRAP_W-1 -: ID_W];

  generate
    if (ID_W <= 4) begin : g_narrow_id
      // target in the top bits, full 8-bit cause in the bottom byte
      logic unused_mid;
      assign unused_mid = ^trap_val[TRAP_W-ID_W-1:CAUSE_W];
      assign cause = trap_val[CAUSE_W-1:0];
    end else begin : g_wide_id
      // wide target field leaves room for only 16 trap kinds
      logic unused_mid;
      assign unused_mid = ^trap_val[TRAP_W-ID_W-1:4];
      assign cause = {{(CAUSE_W-4){1'b0}}, trap_val[3:0]};
    end
  endgenerate

  assign local_hit = (tgt == '0) || (tgt == core_id);
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               mask,
  input  logic               trap_go,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic               ext_go,
  input  logic [CAUSE_W-1:0] ext_cause,
  input  logic               ipi_in_valid,
  input  logic [CAUSE_W-1:0] ipi_in_cause,
  output logic               take,
  output logic [CAUSE_W-1:0] take_cause,
  output logic               pend
);
  src_e               src;
  logic               pend_q;
  logic [CAUSE_W-1:0] pcause_q;
  logic               ipi_avail;
  logic [CAUSE_W-1:0] ipi_cause;

  assign ipi_avail = pend_q | ipi_in_valid;
  assign ipi_cause = pend_q ? pcause_q : ipi_in_cause;

  always_comb begin
    src        = SRC_NONE;
    take_cause = '0;
    if (!mask) begin
      if (trap_go) begin
        src        = SRC_TRAP;
        take_cause = trap_cause;
      end else if (ext_go) begin
        src        = SRC_EXT;
        take_cause = ext_cause;
      end else if (ipi_avail) begin
        src        = SRC_IPI;
        take_cause = ipi_cause;
      end
    end
  end

  assign take = (src != SRC_NONE);
  assign pend = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      pcause_q <= '0;
    end else if (src == SRC_IPI && pend_q) begin
      // latched one served; a fresh arrival takes its place
      pend_q   <= ipi_in_valid;
      pcause_q <= ipi_in_cause;
    end else if (ipi_in_valid && !pend_q && src != SRC_IPI) begin
      pend_q   <= 1'b1;
      pcause_q <= ipi_in_cause;
    end
  end
endmodule

// File: rtl/irq_ctx.sv
module irq_ctx
  import irq_pkg::*;
#(
  parameter int          AW      = 32,
  parameter int          ST_W    = 4,
  parameter logic [31:0] SP_RST  = 32'h1000_0000,
  parameter logic [31:0] ALT_RST = 32'h2000_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  logic [CAUSE_W-1:0] cause,
  input  logic               ret_go,
  input  logic [AW-1:0]      pc_in,
  input  logic [ST_W-1:0]    status_in,
  input  logic               base_wr,
  input  logic               sp_wr,
  input  logic               alt_wr,
  input  logic [AW-1:0]      wr_data,
  output logic               entry_valid,
  output logic [CAUSE_W-1:0] entry_cause,
  output logic [AW-1:0]      handler_pc,
  output logic [AW-1:0]      saved_pc,
  output logic [ST_W-1:0]    saved_status,
  output logic               in_handler,
  output logic [AW-1:0]      sp_active,
  output logic [AW-1:0]      sp_alt,
  output logic               ret_valid
);
  localparam int BASE_W = AW - VEC_LSB;

  logic [BASE_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q       <= '0;
      entry_valid  <= 1'b0;
      entry_cause  <= '0;
      handler_pc   <= '0;
      saved_pc     <= '0;
      saved_status <= '0;
      in_handler   <= 1'b0;
      sp_active    <= SP_RST[AW-1:0];
      sp_alt       <= ALT_RST[AW-1:0];
      ret_valid    <= 1'b0;
    end else begin
      entry_valid <= take;
      ret_valid   <= ret_go;
      if (base_wr) base_q <= wr_data[AW-1:VEC_LSB];
      if (take) begin
        in_handler   <= 1'b1;
        saved_pc     <= pc_in;
        saved_status <= status_in;
        entry_cause  <= cause;
        handler_pc   <= {base_q, cause, {SLOT_LSB{1'b0}}};
        sp_active    <= sp_alt;
        sp_alt       <= sp_active;
      end else if (ret_go) begin
        in_handler <= 1'b0;
        sp_active  <= sp_alt;
        sp_alt     <= sp_active;
      end else begin
        if (sp_wr)  sp_active <= wr_data;
        if (alt_wr) sp_alt    <= wr_data;
      end
    end
  end
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
  import irq_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          ST_W      = 4,
  parameter int          ID_W      = 4,
  parameter int          TRAP_W    = 16,
  parameter int          HOME_CORE = 1,
  parameter logic [31:0] SP_RST    = 32'h1000_0000,
  parameter logic [31:0] ALT_RST   = 32'h2000_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ID_W-1:0]    core_id,
  input  logic [AW-1:0]      pc_in,
  input  logic [ST_W-1:0]    status_in,
  input  logic               base_wr,
  input  logic               sp_wr,
  input  logic               alt_wr,
  input  logic [AW-1:0]      wr_data,
  input  logic               trap_req,
  input  logic [TRAP_W-1:0]  trap_val,
  input  logic               ext_irq,
  input  logic [7:0]         ext_cause,
  input  logic               ipi_in_valid,
  input  logic [7:0]         ipi_in_cause,
  input  logic               ret_req,
  output logic               entry_valid,
  output logic [7:0]         entry_cause,
  output logic [AW-1:0]      handler_pc,
  output logic [AW-1:0]      saved_pc,
  output logic [ST_W-1:0]    saved_status,
  output logic               in_handler,
  output logic [AW-1:0]      sp_active,
  output logic [AW-1:0]      sp_alt,
  output logic               ret_valid,
  output logic               ipi_pending,
  output logic               ipi_out_valid,
  output logic [ID_W-1:0]    ipi_out_target,
  output logic [7:0]         ipi_out_cause
);
  localparam logic [ID_W-1:0] HOME_ID = ID_W'(HOME_CORE);

  logic [ID_W-1:0]    t_tgt;
  logic [CAUSE_W-1:0] t_cause;
  logic               t_local;
  logic               take;
  logic [CAUSE_W-1:0] take_cause;
  logic               ret_go;
  logic               ext_go;

  irq_trap_route #(.ID_W(ID_W), .TRAP_W(TRAP_W)) u_route (
    .trap_val  (trap_val),
    .core_id   (core_id),
    .tgt       (t_tgt),
    .cause     (t_cause),
    .local_hit (t_local)
  );

  assign ext_go = ext_irq && (core_id == HOME_ID);
  assign ret_go = ret_req && in_handler;

  irq_pick u_pick (
    .clk          (clk),
    .rst          (rst),
    .mask         (in_handler),
    .trap_go      (trap_req && t_local),
    .trap_cause   (t_cause),
    .ext_go       (ext_go),
    .ext_cause    (ext_cause),
    .ipi_in_valid (ipi_in_valid),
    .ipi_in_cause (ipi_in_cause),
    .take         (take),
    .take_cause   (take_cause),
    .pend         (ipi_pending)
  );

  irq_ctx #(.AW(AW), .ST_W(ST_W), .SP_RST(SP_RST), .ALT_RST(ALT_RST)) u_ctx (
    .clk          (clk),
    .rst          (rst),
    .take         (take),
    .cause        (take_cause),
    .ret_go       (ret_go),
    .pc_in        (pc_in),
    .status_in    (status_in),
    .base_wr      (base_wr),
    .sp_wr        (sp_wr),
    .alt_wr       (alt_wr),
    .wr_data      (wr_data),
    .entry_valid  (entry_valid),
    .entry_cause  (entry_cause),
    .handler_pc   (handler_pc),
    .saved_pc     (saved_pc),
    .saved_status (saved_status),
    .in_handler   (in_handler),
    .sp_active    (sp_active),
    .sp_alt       (sp_alt),
    .ret_valid    (ret_valid)
  );

  // forward remote traps; the mask does not apply here
  always_ff @(posedge clk) begin
    if (rst) begin
      ipi_out_valid  <= 1'b0;
      ipi_out_target <= '0;
      ipi_out_cause  <= '0;
    end else begin
      ipi_out_valid <= trap_req && !t_local;
      if (trap_req && !t_local) begin
        ipi_out_target <= t_tgt;
        ipi_out_cause  <= t_cause;
      end
    end
  end
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int AW   = 32,
  parameter int ID_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   pc_in,
  input logic            entry_valid,
  input logic [7:0]      entry_cause,
  input logic [AW-1:0]   handler_pc,
  input logic [AW-1:0]   saved_pc,
  input logic            in_handler,
  input logic [AW-1:0]   sp_active,
  input logic [AW-1:0]   sp_alt,
  input logic            ret_valid,
  input logic            ipi_out_valid,
  input logic [ID_W-1:0] ipi_out_target
);
  AST_ENTRY_SETS_MASK: assert property (@(posedge clk) disable iff (rst)
    entry_valid |-> in_handler); // R2

  AST_ENTRY_SAVES_PC: assert property (@(posedge clk) disable iff (rst)
    entry_valid |-> saved_pc == $past(pc_in)); // R2

  AST_VECTOR_SLOT: assert property (@(posedge clk) disable iff (rst)
    entry_valid |-> (handler_pc[1:0] == 2'b00 && handler_pc[9:2] == entry_cause)); // R3

  AST_ENTRY_SWAPS_SP: assert property (@(posedge clk) disable iff (rst)
    entry_valid |-> (sp_active == $past(sp_alt) && sp_alt == $past(sp_active))); // R4

  AST_RET_SWAPS_SP: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> (sp_active == $past(sp_alt) && sp_alt == $past(sp_active))); // R4

  AST_RET_UNMASKS: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> !in_handler); // R5

  AST_NO_NESTED_ENTRY: assert property (@(posedge clk) disable iff (rst)
    entry_valid |-> !$past(in_handler)); // R10

  AST_FWD_NOT_LOCAL: assert property (@(posedge clk) disable iff (rst)
    ipi_out_valid |-> ipi_out_target != '0); // R7

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(entry_valid && ret_valid)); // R5
endmodule

bind irq_entry_unit irq_entry_chk #(.AW(AW), .ID_W(ID_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .pc_in          (pc_in),
  .entry_valid    (entry_valid),
  .entry_cause    (entry_cause),
  .handler_pc     (handler_pc),
  .saved_pc       (saved_pc),
  .in_handler     (in_handler),
  .sp_active      (sp_active),
  .sp_alt         (sp_alt),
  .ret_valid      (ret_valid),
  .ipi_out_valid  (ipi_out_valid),
  .ipi_out_target (ipi_out_target)
);

// File: tb/irq_entry_unit_bench.sv
module irq_entry_unit_bench;
  localparam logic [31:0] SPR = 32'h1000_0000;
  localparam logic [31:0] ALR = 32'h2000_0000;
  localparam int HOME = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  core_id = 4'd1;
  logic [31:0] pc_in = '0;
  logic [3:0]  status_in = '0;
  logic        base_wr = 0, sp_wr = 0, alt_wr = 0;
  logic [31:0] wr_data = '0;
  logic        trap_req = 0;
  logic [15:0] trap_val = '0;
  logic        ext_irq = 0;
  logic [7:0]  ext_cause = '0;
  logic        ipi_in_valid = 0;
  logic [7:0]  ipi_in_cause = '0;
  logic        ret_req = 0;

  logic        entry_valid, in_handler, ret_valid, ipi_pending, ipi_out_valid;
  logic [7:0]  entry_cause, ipi_out_cause;
  logic [31:0] handler_pc, saved_pc, sp_active, sp_alt;
  logic [3:0]  saved_status, ipi_out_target;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit live = 0;

  always #2 clk = ~clk;

  irq_entry_unit #(.HOME_CORE(HOME), .SP_RST(SPR), .ALT_RST(ALR)) u_irq_entry_unit (
    .clk(clk), .rst(rst), .core_id(core_id), .pc_in(pc_in), .status_in(status_in),
    .base_wr(base_wr), .sp_wr(sp_wr), .alt_wr(alt_wr), .wr_data(wr_data),
    .trap_req(trap_req), .trap_val(trap_val), .ext_irq(ext_irq), .ext_cause(ext_cause),
    .ipi_in_valid(ipi_in_valid), .ipi_in_cause(ipi_in_cause), .ret_req(ret_req),
    .entry_valid(entry_valid), .entry_cause(entry_cause), .handler_pc(handler_pc),
    .saved_pc(saved_pc), .saved_status(saved_status), .in_handler(in_handler),
    .sp_active(sp_active), .sp_alt(sp_alt), .ret_valid(ret_valid),
    .ipi_pending(ipi_pending), .ipi_out_valid(ipi_out_valid),
    .ipi_out_target(ipi_out_target), .ipi_out_cause(ipi_out_cause)
  );

  // reference model state
  bit          m_in, m_ev, m_rv, m_pend, m_ov;
  logic [31:0] m_sp, m_alt, m_base, m_spc, m_hpc;
  logic [3:0]  m_sst, m_ot;
  logic [7:0]  m_ec, m_pc8, m_oc;

  always @(posedge clk) begin
    if (rst) begin
      m_in = 0; m_ev = 0; m_rv = 0; m_pend = 0; m_ov = 0;
      m_sp = SPR; m_alt = ALR; m_base = 0; m_spc = 0; m_hpc = 0;
      m_sst = 0; m_ot = 0; m_ec = 0; m_pc8 = 0; m_oc = 0;
    end else begin
      int src;
      logic [7:0] c;
      logic [31:0] tmp;
      bit loc, ret;
      loc = (trap_val[15:12] == 0) || (trap_val[15:12] == core_id);
      m_ov = trap_req && !loc;
      if (m_ov) begin m_ot = trap_val[15:12]; m_oc = trap_val[7:0]; end
      src = 0; c = 0;
      if (!m_in) begin
        if (trap_req && loc) begin src = 1; c = trap_val[7:0]; end
        else if (ext_irq && core_id == HOME) begin src = 2; c = ext_cause; end
        else if (m_pend || ipi_in_valid) begin src = 3; c = m_pend ? m_pc8 : ipi_in_cause; end
      end
      if (src == 3 && m_pend) begin m_pend = ipi_in_valid; m_pc8 = ipi_in_cause; end
      else if (ipi_in_valid && !m_pend && src != 3) begin m_pend = 1; m_pc8 = ipi_in_cause; end
      ret = ret_req && m_in;
      m_ev = (src != 0);
      m_rv = ret;
      if (m_ev) begin
        m_in = 1; m_spc = pc_in; m_sst = status_in; m_ec = c;
        m_hpc = m_base | (32'(c) << 2);
        tmp = m_sp; m_sp = m_alt; m_alt = tmp;
      end else if (ret) begin
        m_in = 0; tmp = m_sp; m_sp = m_alt; m_alt = tmp;
      end else begin
        if (sp_wr) m_sp = wr_data;
        if (alt_wr) m_alt = wr_data;
      end
      if (base_wr) m_base = {wr_data[31:10], 10'd0};
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (live && !rst) begin
      chk("R2", "entry_valid", entry_valid, m_ev);
      chk("R2", "saved_pc", saved_pc, m_spc);
      chk("R2", "saved_status", saved_status, m_sst);
      chk("R6", "entry_cause", entry_cause, m_ec);
      chk("R3", "handler_pc", handler_pc, m_hpc);
      chk("R10", "in_handler", in_handler, m_in);
      chk("R4", "sp_active", sp_active, m_sp);
      chk("R12", "sp_alt", sp_alt, m_alt);
      chk("R5", "ret_valid", ret_valid, m_rv);
      chk("R11", "ipi_pending", ipi_pending, m_pend);
      chk("R8", "ipi_out_valid", ipi_out_valid, m_ov);
      chk("R8", "ipi_out_target", ipi_out_target, m_ot);
      chk("R8", "ipi_out_cause", ipi_out_cause, m_oc);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic quiet();
    base_wr = 0; sp_wr = 0; alt_wr = 0; trap_req = 0; ext_irq = 0;
    ipi_in_valid = 0; ret_req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R1", "in_handler", in_handler, 0);
    chk("R1", "sp_active", sp_active, SPR);
    chk("R1", "sp_alt", sp_alt, ALR);
    chk("R1", "ipi_pending", ipi_pending, 0);
    chk("R1", "entry_valid", entry_valid, 0);
    rst = 0; live = 1;

    base_wr = 1; wr_data = 32'h0001_23FF; tick(); quiet();
    sp_wr = 1; wr_data = 32'hAAAA_0000; tick(); quiet();
    alt_wr = 1; wr_data = 32'hBBBB_0000; tick(); quiet();
    chk("R12", "sp_active loaded", sp_active, 32'hAAAA_0000);
    chk("R12", "sp_alt loaded", sp_alt, 32'hBBBB_0000);

    trap_req = 1; trap_val = 16'h002A; pc_in = 32'h400; status_in = 4'h5;
    tick(); quiet();
    chk("R2", "entry pulse", entry_valid, 1);
    chk("R2", "saved pc", saved_pc, 32'h400);
    chk("R3", "vector", handler_pc, 32'h0001_20A8);
    chk("R4", "swap on entry", sp_active, 32'hBBBB_0000);
    tick();
    trap_req = 1; trap_val = 16'h1033; ext_irq = 1; ext_cause = 8'h11;
    ipi_in_valid = 1; ipi_in_cause = 8'h55; pc_in = 32'h900;
    tick();
    chk("R10", "masked no entry", entry_valid, 0);
    chk("R10", "saved pc kept", saved_pc, 32'h400);
    chk("R11", "ipi latched", ipi_pending, 1);
    trap_req = 0; ipi_in_cause = 8'h66; tick(); ipi_in_valid = 0;
    ret_req = 1; tick(); ret_req = 0;
    chk("R5", "ret pulse", ret_valid, 1);
    chk("R4", "swap back", sp_active, 32'hAAAA_0000);
    chk("R10", "no entry in ret cycle", entry_valid, 0);
    tick();
    chk("R6", "ext beats pending ipi", entry_cause, 8'h11);
    chk("R10", "level ext taken after return", entry_valid, 1);
    ext_irq = 0;
    ret_req = 1; tick(); ret_req = 0; tick();
    chk("R11", "pending ipi taken", entry_cause, 8'h55);
    chk("R11", "second ipi dropped", ipi_pending, 0);
    ret_req = 1; tick(); ret_req = 0; tick();
    ret_req = 1; tick(); ret_req = 0;
    chk("R5", "ret ignored when idle", ret_valid, 0);
    chk("R5", "sp unchanged", sp_active, 32'hAAAA_0000);

    trap_req = 1; trap_val = 16'h1044; ext_irq = 1; ext_cause = 8'h12;
    ipi_in_valid = 1; ipi_in_cause = 8'h56;
    tick(); quiet();
    chk("R7", "own id is local", entry_valid, 1);
    chk("R6", "trap wins", entry_cause, 8'h44);
    chk("R11", "loser ipi latched", ipi_pending, 1);
    ret_req = 1; tick(); ret_req = 0; tick();
    chk("R11", "latched ipi after return", entry_cause, 8'h56);
    trap_req = 1; trap_val = 16'h5077; ret_req = 1;
    tick(); quiet();
    chk("R8", "forward while in return", ipi_out_valid, 1);
    chk("R8", "forward target", ipi_out_target, 4'h5);
    chk("R8", "forward cause", ipi_out_cause, 8'h77);
    chk("R8", "no local entry", entry_valid, 0);
    tick();
    chk("R8", "forward pulse ends", ipi_out_valid, 0);

    core_id = 4'd3; ext_irq = 1; ext_cause = 8'h20; tick(); tick();
    chk("R9", "not home core", in_handler, 0);
    chk("R9", "no entry off home", entry_valid, 0);
    core_id = 4'd1; tick(); ext_irq = 0;
    chk("R9", "home core takes ext", entry_cause, 8'h20);
    sp_wr = 1; wr_data = 32'hCCCC_0000; ret_req = 1; tick(); quiet();
    chk("R12", "write dropped in ret cycle", sp_active, 32'hAAAA_0000);

    for (int i = 0; i < 6000; i++) begin
      core_id = ($urandom % 4 == 0) ? 4'd3 : 4'd1;
      pc_in = $urandom; status_in = 4'($urandom);
      wr_data = $urandom;
      base_wr = ($urandom % 16 == 0);
      sp_wr = ($urandom % 8 == 0);
      alt_wr = ($urandom % 8 == 0);
      trap_req = ($urandom % 5 == 0);
      case ($urandom % 4)
        0: trap_val = {4'd0, 4'($urandom), 8'($urandom)};
        1: trap_val = {4'd1, 4'($urandom), 8'($urandom)};
        2: trap_val = {4'd3, 4'($urandom), 8'($urandom)};
        default: trap_val = {4'd9, 4'($urandom), 8'($urandom)};
      endcase
      ext_irq = ($urandom % 6 == 0); ext_cause = 8'($urandom);
      ipi_in_valid = ($urandom % 5 == 0); ipi_in_cause = 8'($urandom);
      ret_req = ($urandom % 3 == 0);
      tick();
    end
    quiet(); tick(); tick();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule